// File: doc/BRIEF.md
# Software Flow-Control Character Detector

This block sits between a serial receiver and its receive FIFO. It watches every received character and recognises the programmed flow-control characters. Stop characters raise a transmit-suspend level. Start characters lower it again. Flow-control characters are removed from the stream, so the FIFO only ever sees user data. Detection either looks at one character, or needs two consecutive characters that match a programmed first/second pair.

When flow control is off, the block can instead run in a marker mode. In this mode every character reaches the FIFO, and a character that equals the second stop character raises a status flag. Comparisons use only the low 5, 6, 7 or 8 bits, as set by the word-length field. The transmitter reads `tx_suspend` and stops only after the character it is currently sending has finished; that part of the behaviour belongs to the transmitter. Received strobes come from a serial shifter, so two strobes are always separated by at least one idle clock.

Top module: `xonxoff_detect`

## Requirements
- R1: When flow control is off (`fc_en`=0), and in single mode for a character that matches neither `xoff1` nor `xon1`, the character goes out on `fifo_we`/`fifo_data` combinationally, in the same cycle as its `rx_valid` strobe.
- R2: In single mode (`fc_en`=1, `fc_pair`=0), a character that matches `xoff1` is not written to the FIFO. `tx_suspend` is 1 from the next cycle on.
- R3: In single mode, a character that matches `xon1` and not `xoff1` is not written to the FIFO. It clears `tx_suspend` and `flow_flag` from the next cycle.
- R4: A stop match sets `flow_flag` only when `xoff_ie`=1. `irq` equals `flow_flag` when `int_en`=1 and is 0 when `int_en`=0.
- R5: Only the low N bits take part in a comparison, with bit 0 as the first received bit. `word_len` 00 gives N=5, 01 gives N=6, 10 gives N=7 and 11 gives N=8.
- R6: In pair mode (`fc_en`=1, `fc_pair`=1), `xoff1` followed by `xoff2` sets `tx_suspend`, and `xon1` followed by `xon2` clears it. Neither character of a matched pair is written to the FIFO.
- R7: In pair mode, a held first character is released if the next character does not complete its pair. The held character is written in the strobe cycle of the next character, and the next character follows in the cycle after, so received order is kept. If the next character is itself a first character, it is held in place of the one released.
- R8: In marker mode (`fc_en`=0, `spec_en`=1), every character is written to the FIFO. A match with `xoff2` sets `flow_flag` and leaves `tx_suspend` unchanged.
- R9: A pulse on `flag_clr` clears `flow_flag`. A flag set in the same cycle takes priority over the clear.
- R10: After reset, `tx_suspend`, `flow_flag`, `irq` and `fifo_we` are all 0.
- R11: `tx_suspend` changes only in the cycle after an `rx_valid` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | One-cycle strobe for a received character |
| rx_data | input | 8 | Received character |
| word_len | input | 2 | Character length select (00=5 … 11=8 bits) |
| fc_en | input | 1 | Enable software flow control |
| fc_pair | input | 1 | Two-character match mode |
| spec_en | input | 1 | Marker mode, active while `fc_en`=0 |
| xon1 | input | 8 | First start character |
| xon2 | input | 8 | Second start character |
| xoff1 | input | 8 | First stop character |
| xoff2 | input | 8 | Second stop character, also the marker character |
| xoff_ie | input | 1 | Allow a stop match to set `flow_flag` |
| int_en | input | 1 | Interrupt output enable |
| flag_clr | input | 1 | Clear pulse for `flow_flag` |
| fifo_we | output | 1 | FIFO write strobe |
| fifo_data | output | 8 | Data written to the FIFO |
| tx_suspend | output | 1 | Transmit-suspend request |
| flow_flag | output | 1 | Flow-control / marker status flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a broken pair. Here a held first character has to be released while a new character arrives, and the second character must still reach the FIFO one cycle later, in order. The stimulus sends a first stop character followed by unrelated data. It also sends a stop character twice in a row before its partner, so that the held slot is released and refilled in the same cycle. The bench checks the FIFO port directly in the strobe cycle and in the cycle after.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
    localparam int CW = 8;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_OFF  = 2'd1,
        K_ON   = 2'd2
    } pend_kind_t;

    typedef struct packed {
        logic          pend_v;
        pend_kind_t    kind;
        logic [CW-1:0] pend;
        logic          carry_v;
        logic [CW-1:0] carry;
        logic          susp;
        logic          flag;
    } fcd_state_t;

    localparam int IDX_OFF1 = 0;
    localparam int IDX_OFF2 = 1;
    localparam int IDX_ON1  = 2;
    localparam int IDX_ON2  = 3;
    localparam int NREF     = 4;
endpackage

// File: rtl/fcd_mask.sv
module fcd_mask #(
    parameter int CW    = 8,
    parameter int MINW  = 5
) (
    input  logic [1:0]    word_len,
    output logic [CW-1:0] mask
);
    localparam int LW = $clog2(CW + 1);

    logic [LW-1:0] nbits;

    always_comb begin
        nbits = LW'(MINW) + LW'(word_len);
        for (int i = 0; i < CW; i++) begin
            mask[i] = (LW'(i) < nbits);
        end
    end
endmodule

// File: rtl/fcd_cmp.sv
module fcd_cmp #(
    parameter int CW = 8
) (
    input  logic [CW-1:0] ch,
    input  logic [CW-1:0] ref_ch,
    input  logic [CW-1:0] mask,
    output logic          hit
);
    assign hit = ((ch ^ ref_ch) & mask) == '0;
endmodule

// File: rtl/xonxoff_detect.sv
module xonxoff_detect
    import fcd_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [CW-1:0] rx_data,
    input  logic [1:0]    word_len,
    input  logic          fc_en,
    input  logic          fc_pair,
    input  logic          spec_en,
    input  logic [CW-1:0] xon1,
    input  logic [CW-1:0] xon2,
    input  logic [CW-1:0] xoff1,
    input  logic [CW-1:0] xoff2,
    input  logic          xoff_ie,
    input  logic          int_en,
    input  logic          flag_clr,
    output logic          fifo_we,
    output logic [CW-1:0] fifo_data,
    output logic          tx_suspend,
    output logic          flow_flag,
    output logic          irq
);
    fcd_state_t    q, d;
    logic [CW-1:0] mask;
    logic [CW-1:0] refs [NREF];
    logic [NREF-1:0] hit;

    assign refs[IDX_OFF1] = xoff1;
    assign refs[IDX_OFF2] = xoff2;
    assign refs[IDX_ON1]  = xon1;
    assign refs[IDX_ON2]  = xon2;

    fcd_mask #(.CW(CW), .MINW(5)) u_mask (
        .word_len (word_len),
        .mask     (mask)
    );

    for (genvar g = 0; g < NREF; g++) begin : g_cmp
        fcd_cmp #(.CW(CW)) u_cmp (
            .ch     (rx_data),
            .ref_ch (refs[g]),
            .mask   (mask),
            .hit    (hit[g])
        );
    end

    logic          we_d;
    logic [CW-1:0] wd_d;

    always_comb begin
        d    = q;
        we_d = 1'b0;
        wd_d = '0;

        // release of a character displaced by a broken pair
        if (q.carry_v) begin
            we_d      = 1'b1;
            wd_d      = q.carry;
            d.carry_v = 1'b0;
        end

        if (flag_clr) d.flag = 1'b0;

        if (rx_valid) begin
            if (fc_en && !fc_pair) begin
                if (hit[IDX_OFF1]) begin
                    d.susp = 1'b1;
                    if (xoff_ie) d.flag = 1'b1;
                end else if (hit[IDX_ON1]) begin
                    d.susp = 1'b0;
                    d.flag = 1'b0;
                end else begin
                    we_d = 1'b1;
                    wd_d = rx_data;
                end
            end else if (fc_en) begin
                if (q.pend_v && q.kind == K_OFF && hit[IDX_OFF2]) begin
                    d.pend_v = 1'b0;
                    d.kind   = K_NONE;
                    d.susp   = 1'b1;
                    if (xoff_ie) d.flag = 1'b1;
                end else if (q.pend_v && q.kind == K_ON && hit[IDX_ON2]) begin
                    d.pend_v = 1'b0;
                    d.kind   = K_NONE;
                    d.susp   = 1'b0;
                    d.flag   = 1'b0;
                end else begin
                    if (q.pend_v) begin
                        we_d     = 1'b1;
                        wd_d     = q.pend;
                        d.pend_v = 1'b0;
                        d.kind   = K_NONE;
                    end
                    if (hit[IDX_OFF1] || hit[IDX_ON1]) begin
                        d.pend_v = 1'b1;
                        d.kind   = hit[IDX_OFF1] ? K_OFF : K_ON;
                        d.pend   = rx_data;
                    end else if (q.pend_v) begin
                        d.carry_v = 1'b1;
                        d.carry   = rx_data;
                    end else begin
                        we_d = 1'b1;
                        wd_d = rx_data;
                    end
                end
            end else begin
                we_d = 1'b1;
                wd_d = rx_data;
                if (spec_en && hit[IDX_OFF2]) d.flag = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign fifo_we    = we_d;
    assign fifo_data  = wd_d;
    assign tx_suspend = q.susp;
    assign flow_flag  = q.flag;
    assign irq        = q.flag & int_en;
endmodule

// File: rtl/fcd_chk.sv
module fcd_chk
    import fcd_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid,
    input logic [CW-1:0] rx_data,
    input logic [1:0]    word_len,
    input logic          fc_en,
    input logic          fc_pair,
    input logic          spec_en,
    input logic [CW-1:0] xon1,
    input logic [CW-1:0] xoff1,
    input logic [CW-1:0] xoff2,
    input logic          int_en,
    input logic          fifo_we,
    input logic [CW-1:0] fifo_data,
    input logic          tx_suspend,
    input logic          flow_flag,
    input logic          irq
);
    logic [CW-1:0] msk;
    logic          m_off1, m_on1, m_off2, single_m;

    assign msk      = {CW{1'b1}} >> (2'd3 - word_len);
    assign m_off1   = (rx_data & msk) == (xoff1 & msk);
    assign m_on1    = (rx_data & msk) == (xon1 & msk);
    assign m_off2   = (rx_data & msk) == (xoff2 & msk);
    assign single_m = fc_en && !fc_pair;

    AST_XOFF_SUSPENDS: assert property (@(posedge clk) disable iff (!rst_n)
        single_m && rx_valid && m_off1 |=> tx_suspend); // R2

    AST_XOFF_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        single_m && rx_valid && m_off1 && !$past(rx_valid) |-> !fifo_we); // R2

    AST_XON_RESUMES: assert property (@(posedge clk) disable iff (!rst_n)
        single_m && rx_valid && m_on1 && !m_off1 |=> !tx_suspend && !flow_flag); // R3

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |-> !irq); // R4

    AST_MARKER_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        !fc_en && rx_valid && !$past(rx_valid) |-> fifo_we && fifo_data == rx_data); // R8

    AST_MARKER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !fc_en && spec_en && rx_valid && m_off2 |=> flow_flag); // R8

    AST_SUSP_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable(tx_suspend)); // R11
endmodule

bind xonxoff_detect fcd_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .word_len   (word_len),
    .fc_en      (fc_en),
    .fc_pair    (fc_pair),
    .spec_en    (spec_en),
    .xon1       (xon1),
    .xoff1      (xoff1),
    .xoff2      (xoff2),
    .int_en     (int_en),
    .fifo_we    (fifo_we),
    .fifo_data  (fifo_data),
    .tx_suspend (tx_suspend),
    .flow_flag  (flow_flag),
    .irq        (irq)
);

// File: tb/xonxoff_detect_tb.sv
module xonxoff_detect_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic [1:0] word_len = 2'b11;
    logic       fc_en = 1'b0, fc_pair = 1'b0, spec_en = 1'b0;
    logic [7:0] xon1 = 8'h11, xon2 = 8'h91, xoff1 = 8'h13, xoff2 = 8'h93;
    logic       xoff_ie = 1'b1, int_en = 1'b1, flag_clr = 1'b0;
    logic       fifo_we, tx_suspend, flow_flag, irq;
    logic [7:0] fifo_data;

    int errors = 0;
    int checks = 0;
    logic       ow, ow2;
    logic [7:0] od, od2;

    always #4 clk = ~clk;

    xonxoff_detect u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .word_len(word_len), .fc_en(fc_en), .fc_pair(fc_pair), .spec_en(spec_en),
        .xon1(xon1), .xon2(xon2), .xoff1(xoff1), .xoff2(xoff2),
        .xoff_ie(xoff_ie), .int_en(int_en), .flag_clr(flag_clr),
        .fifo_we(fifo_we), .fifo_data(fifo_data), .tx_suspend(tx_suspend),
        .flow_flag(flow_flag), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // strobe one character; record FIFO port in the strobe cycle and the next
    task automatic send(input logic [7:0] c);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = c;
        #1;
        ow = fifo_we; od = fifo_data;
        @(negedge clk);
        rx_valid = 1'b0;
        #1;
        ow2 = fifo_we; od2 = fifo_data;
        @(negedge clk);
    endtask

    task automatic t_reset();
        #1;
        chk("R10 suspend", int'(tx_suspend), 0);
        chk("R10 flag", int'(flow_flag), 0);
        chk("R10 irq", int'(irq), 0);
        chk("R10 we", int'(fifo_we), 0);
    endtask

    task automatic t_pass();
        fc_en = 0; spec_en = 0;
        send(8'h13);
        chk("R1 off we", int'(ow), 1);
        chk("R1 off data", int'(od), 'h13);
        chk("R1 off suspend", int'(tx_suspend), 0);
        fc_en = 1; fc_pair = 0;
        send(8'h41);
        chk("R1 single we", int'(ow), 1);
        chk("R1 single data", int'(od), 'h41);
        chk("R1 no dup", int'(ow2), 0);
    endtask

    task automatic t_single();
        fc_en = 1; fc_pair = 0; xoff_ie = 1; int_en = 1;
        send(8'h13);
        chk("R2 dropped", int'(ow | ow2), 0);
        chk("R2 suspend", int'(tx_suspend), 1);
        chk("R4 flag", int'(flow_flag), 1);
        chk("R4 irq", int'(irq), 1);
        int_en = 0; #1;
        chk("R4 irq masked", int'(irq), 0);
        int_en = 1;
        fc_pair = 1; spec_en = 1;
        repeat (3) @(negedge clk);
        #1;
        chk("R11 hold", int'(tx_suspend), 1);
        fc_pair = 0; spec_en = 0;
        send(8'h11);
        chk("R3 dropped", int'(ow | ow2), 0);
        chk("R3 suspend", int'(tx_suspend), 0);
        chk("R3 flag", int'(flow_flag), 0);
    endtask

    task automatic t_ie();
        xoff_ie = 0;
        send(8'h13);
        chk("R4 ie off suspend", int'(tx_suspend), 1);
        chk("R4 ie off flag", int'(flow_flag), 0);
        xoff_ie = 1;
        send(8'h11);
    endtask

    task automatic t_wlen();
        word_len = 2'b00;
        send(8'hF3);
        chk("R5 5bit match", int'(tx_suspend), 1);
        chk("R5 5bit drop", int'(ow), 0);
        send(8'hF1);
        chk("R5 5bit xon", int'(tx_suspend), 0);
        send(8'h03);
        chk("R5 bit4 differs", int'(ow), 1);
        word_len = 2'b11;
        send(8'h93);
        chk("R5 8bit bit7 differs", int'(ow), 1);
        chk("R5 8bit no suspend", int'(tx_suspend), 0);
        word_len = 2'b10;
        send(8'h93);
        chk("R5 7bit match", int'(tx_suspend), 1);
        send(8'h11);
        word_len = 2'b01;
        send(8'h53);
        chk("R5 6bit bit6 ignored", int'(tx_suspend), 1);
        send(8'h11);
        word_len = 2'b11;
    endtask

    task automatic t_dual();
        fc_en = 1; fc_pair = 1;
        send(8'h13);
        chk("R6 first held", int'(ow | ow2), 0);
        chk("R6 first no suspend", int'(tx_suspend), 0);
        send(8'h93);
        chk("R6 pair dropped", int'(ow | ow2), 0);
        chk("R6 pair suspend", int'(tx_suspend), 1);
        send(8'h11);
        send(8'h91);
        chk("R6 xon pair dropped", int'(ow | ow2), 0);
        chk("R6 xon pair resume", int'(tx_suspend), 0);
    endtask

    task automatic t_dual_miss();
        fc_en = 1; fc_pair = 1;
        send(8'h13);
        send(8'h41);
        chk("R7 held released we", int'(ow), 1);
        chk("R7 held released data", int'(od), 'h13);
        chk("R7 second we", int'(ow2), 1);
        chk("R7 second data", int'(od2), 'h41);
        chk("R7 no suspend", int'(tx_suspend), 0);
        send(8'h13);
        send(8'h13);
        chk("R7 refill release", int'(od), 'h13);
        chk("R7 refill we", int'(ow), 1);
        chk("R7 refill no extra", int'(ow2), 0);
        send(8'h93);
        chk("R7 refill completes pair", int'(tx_suspend), 1);
        chk("R7 pair dropped", int'(ow | ow2), 0);
        send(8'h11);
        send(8'h91);
    endtask

    task automatic t_special();
        fc_en = 0; spec_en = 1;
        send(8'h93);
        chk("R8 forwarded we", int'(ow), 1);
        chk("R8 forwarded data", int'(od), 'h93);
        chk("R8 flag", int'(flow_flag), 1);
        chk("R8 suspend unchanged", int'(tx_suspend), 0);
        @(negedge clk); flag_clr = 1;
        @(negedge clk); flag_clr = 0; #1;
        chk("R9 cleared", int'(flow_flag), 0);
        @(negedge clk);
        rx_valid = 1; rx_data = 8'h93; flag_clr = 1;
        @(negedge clk);
        rx_valid = 0; flag_clr = 0; #1;
        chk("R9 set wins", int'(flow_flag), 1);
        spec_en = 0;
        send(8'h93);
        chk("R8 spec off passes", int'(ow), 1);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_pass();
        t_single();
        t_ie();
        t_wlen();
        t_dual();
        t_dual_miss();
        t_special();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule